// File: doc/BRIEF.md
# Clock-Enable Register with Folded Soft Reset

A register bank of parameterizable width whose flops are all clock-enable flops. It has two resets. The hard reset is active-low and asynchronous. The soft reset is active-low and synchronous, so it needs a running clock.

The soft reset does not sit as a gate between the enable multiplexer and the flop. Instead it is folded into the enable path:

- the data heading into the multiplexer is ANDed with the soft-reset level, so the data becomes zero while soft reset is asserted;
- the multiplexer select is ORed with the asserted soft reset, so the zero is captured.

This leaves the flop's native enable free for the real select and takes a gate out of the data path. The result matches a plain priority chain: hard reset first, then soft reset, then enable.

A mode parameter turns an instance into a toggle register. In that mode, bit i's flop enable is the load enable ANDed with `d[i]`, and its data is the inverted stored bit. The result is an XOR-feedback T flop built from an enable flop. The soft reset is folded into it the same way.

Top module: `en_soft_reg`

## Requirements
- R1: While `rst_hard_n` is 0, `q` is all zeros. It clears asynchronously, without waiting for a clock edge, and this overrides every other input.
- R2: With `rst_hard_n` at 1 and `rst_soft_n` at 0 during a rising edge, `q` is all zeros after that edge, even when `en` is 0.
- R3: Soft reset overrides load. With `rst_soft_n` at 0, `en` at 1 and `d` all ones at an edge, `q` becomes all zeros.
- R4: In load mode (`TOGGLE`=0), with both resets at 1 and `en` at 1 at an edge, `q` takes the value of `d`.
- R5: In load mode, with both resets at 1 and `en` at 0 at an edge, `q` keeps its value, whatever `d` is.
- R6: In toggle mode (`TOGGLE`=1), with both resets at 1, bit i of `q` inverts at an edge when `en` is 1 and `d[i]` is 1. Otherwise that bit holds.
- R7: In toggle mode, soft reset clears `q` to all zeros at an edge, whatever `en` and `d` are.
- R8: Every cycle, `q` equals the value given by the priority chain hard reset > soft reset > enable, in both modes. `WIDTH` defaults to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_hard_n | input | 1 | Asynchronous clear, active low; release assumed synchronized externally |
| rst_soft_n | input | 1 | Synchronous clear, active low |
| en | input | 1 | Load enable (load mode) or toggle qualifier (toggle mode) |
| d | input | WIDTH | Load data (load mode) or per-bit toggle request (toggle mode) |
| q | output | WIDTH | Stored value |

## Verification
Directed patterns separate the cases the folding could get wrong:

- Soft reset with `en` low shows that the select really is forced high.
- Soft reset with `en` high and `d` all ones shows that the data really is masked.
- A hard-reset drop sampled before the next edge separates an asynchronous clear from a synchronous one.
- Alternating load and hold values, and mixed toggle masks, distinguish load from hold and toggle from load.

Random resets, enables and data then compare both modes against a priority-chain model every cycle. This exposes any disagreement in the ordering of the three controls.

// File: rtl/en_soft_reg.sv
module en_soft_reg #(
  parameter int WIDTH  = 8,
  parameter bit TOGGLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_hard_n,
  input  logic             rst_soft_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] sel;
  logic [WIDTH-1:0] nxt;

  generate
    if (TOGGLE) begin : g_tog
      assign sel = ({WIDTH{en}} & d) | {WIDTH{~rst_soft_n}};
      assign nxt = ~q & {WIDTH{rst_soft_n}};
    end else begin : g_load
      assign sel = {WIDTH{en | ~rst_soft_n}};
      assign nxt = d & {WIDTH{rst_soft_n}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_hard_n) begin
    if (!rst_hard_n) q <= ZERO;
    else
      for (int i = 0; i < WIDTH; i++)
        if (sel[i]) q[i] <= nxt[i];
  end

  // R1
  hard_clear_chk: assert property (@(posedge clk) !rst_hard_n |-> q == ZERO);

  // R2
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_hard_n)
    !rst_soft_n |=> q == ZERO);

  generate
    if (TOGGLE) begin : g_tog_chk
      // R6
      toggle_step_chk: assert property (@(posedge clk) disable iff (!rst_hard_n)
        rst_soft_n |=> q == ($past(q) ^ ($past(d) & {WIDTH{$past(en)}})));
    end else begin : g_load_chk
      // R4
      load_chk: assert property (@(posedge clk) disable iff (!rst_hard_n)
        rst_soft_n && en |=> q == $past(d));
      // R5
      hold_chk: assert property (@(posedge clk) disable iff (!rst_hard_n)
        rst_soft_n && !en |=> $stable(q));
    end
  endgenerate
endmodule

// File: tb/en_soft_reg_tb.sv
module en_soft_reg_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_hard_n = 1'b0;
  logic         rst_soft_n = 1'b1;
  logic         en = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q_l, q_t;
  logic [W-1:0] exp_l, exp_t;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  en_soft_reg #(.WIDTH(W), .TOGGLE(1'b0)) u_dut (
    .clk(clk), .rst_hard_n(rst_hard_n), .rst_soft_n(rst_soft_n),
    .en(en), .d(d), .q(q_l));

  en_soft_reg #(.WIDTH(W), .TOGGLE(1'b1)) u_tog (
    .clk(clk), .rst_hard_n(rst_hard_n), .rst_soft_n(rst_soft_n),
    .en(en), .d(d), .q(q_t));

  function automatic logic [W-1:0] ref_load(logic [W-1:0] cur, logic s_n,
                                            logic e, logic [W-1:0] din);
    if (!s_n) return '0;
    else if (e) return din;
    else return cur;
  endfunction

  function automatic logic [W-1:0] ref_tog(logic [W-1:0] cur, logic s_n,
                                           logic e, logic [W-1:0] din);
    if (!s_n) return '0;
    else if (e) return cur ^ din;
    else return cur;
  endfunction

  always @(posedge clk or negedge rst_hard_n) begin
    if (!rst_hard_n) begin
      exp_l = '0;
      exp_t = '0;
    end else begin
      exp_l = ref_load(exp_l, rst_soft_n, en, d);
      exp_t = ref_tog(exp_t, rst_soft_n, en, d);
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(logic h, logic s, logic e, logic [W-1:0] v);
    rst_hard_n = h; rst_soft_n = s; en = e; d = v;
  endtask

  task automatic step(logic h, logic s, logic e, logic [W-1:0] v);
    drive(h, s, e, v);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    step(1'b0, 1'b1, 1'b1, 8'hFF);
    chk("R1 reset state load", q_l, 8'h00);
    chk("R1 reset state toggle", q_t, 8'h00);

    step(1'b1, 1'b1, 1'b1, 8'hA5);
    chk("R4 load A5", q_l, 8'hA5);
    chk("R6 toggle from zero", q_t, 8'hA5);

    step(1'b1, 1'b1, 1'b0, 8'h3C);
    chk("R5 hold with en low", q_l, 8'hA5);
    chk("R6 hold with en low", q_t, 8'hA5);

    step(1'b1, 1'b1, 1'b1, 8'h0F);
    chk("R4 load 0F", q_l, 8'h0F);
    chk("R6 toggle mask 0F", q_t, 8'hAA);

    step(1'b1, 1'b0, 1'b0, 8'hFF);
    chk("R2 soft clear en low", q_l, 8'h00);
    chk("R7 soft clear toggle", q_t, 8'h00);

    step(1'b1, 1'b1, 1'b1, 8'hFF);
    step(1'b1, 1'b0, 1'b1, 8'hFF);
    chk("R3 soft beats load", q_l, 8'h00);
    chk("R7 soft beats toggle", q_t, 8'h00);

    step(1'b1, 1'b1, 1'b1, 8'hFF);
    chk("R4 load FF", q_l, 8'hFF);
    chk("R6 toggle all", q_t, 8'hFF);
    drive(1'b1, 1'b1, 1'b0, 8'h00);
    #2 rst_hard_n = 1'b0;
    #1;
    chk("R1 async clear load", q_l, 8'h00);
    chk("R1 async clear toggle", q_t, 8'h00);
    @(negedge clk);
    step(1'b1, 1'b1, 1'b0, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      chk("R8 model load", q_l, exp_l);
      chk("R8 model toggle", q_t, exp_t);
      step(($urandom % 64) != 0, ($urandom % 8) != 0, $urandom % 2,
           W'($urandom));
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule